// File: doc/BRIEF.md
# Four-Lane Run-Time Window Multiplier

This block weights the samples that enter an FFT with a window function. On each accepted beat it receives four complex samples, which are consecutive points of one frame. Each lane multiplies the real part and the imaginary part of its sample by the same unsigned real coefficient, so the block holds eight multipliers. The results are rounded, clipped to the sample width and delivered three clocks later. The frame-start marker and the valid flag arrive in the same cycle as the data.

The coefficients are held in a table of their own. It has one entry per frame point and is kept apart from any FFT twiddle storage. Reset loads a Hann window into it. Between frames, a single-entry write port can replace any entry, so another window shape can be installed at run time. A write that arrives while a frame is open, or while samples are still in the pipeline, is dropped, and a sticky error flag is raised. A per-beat enable lets a beat pass through unchanged with the same latency as the multiply path.

Top module: `qwin_window4`

## Requirements
- R1: After reset `out_valid` and `cw_err` are 0, and table entry n (0..FRAME_LEN-1) holds round(32768 * (1 - cos(2*pi*n/FRAME_LEN)) / 2), which is a Hann window in unsigned Q1.15.
- R2: A beat accepted with `in_sof`=1 is frame cycle 0. Every other accepted beat takes the previous cycle plus one, wrapping to 0 after FRAME_LEN/4 beats. Lane k (bits [16k+15:16k] of each data bus) in frame cycle c uses table entry 4*c+k.
- R3: With `win_en`=1 on the accepted beat, each output part equals floor((x*w + 16384) / 32768), where x is the signed 16-bit input part and w is the unsigned Q1.15 coefficient. The real and imaginary parts are computed separately.
- R4: A windowed result above 32767 is output as 32767, and a result below -32768 is output as -32768.
- R5: With `win_en`=0 on the accepted beat, both parts of every lane leave the block bit-identical to the input, with the same latency as windowed beats.
- R6: A beat accepted in cycle t appears on the outputs in cycle t+3 when `out_ready` stays 1. `out_valid` and `out_sof` are delayed by the same three cycles.
- R7: `in_ready` equals `out_ready`. While `out_ready` is 0 the whole pipeline holds still, the outputs stay stable, and no beat is lost or reordered.
- R8: When no frame is open and the pipeline is empty, `cw_we`=1 writes `cw_data` to entry `cw_addr`. Beats accepted in later cycles use the new value, and `cw_err` is not raised.
- R9: A frame is open from an accepted beat that is not the last of its frame until the last beat is accepted. A `cw_we` while a frame is open or any pipeline stage holds a beat leaves the table unchanged and sets `cw_err` in the next cycle. `cw_err` then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_en | input | 1 | 1 applies the window to this beat, 0 passes it through |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_sof | input | 1 | Input beat is frame cycle 0 |
| in_re | input | 64 | Real parts, lane k at bits [16k+15:16k], signed |
| in_im | input | 64 | Imaginary parts, same lane layout |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream accepts the output beat; also advances the pipeline |
| out_sof | output | 1 | Output beat starts a frame |
| out_re | output | 64 | Windowed real parts |
| out_im | output | 64 | Windowed imaginary parts |
| cw_we | input | 1 | Coefficient table write strobe |
| cw_addr | input | 6 | Table entry to write |
| cw_data | input | 16 | Unsigned Q1.15 coefficient |
| cw_err | output | 1 | Sticky flag: a write was refused because the block was busy |

## Verification
Each output beat is due exactly three cycles after the cycle in which it was accepted. The error flag is due one cycle after a refused write, and a table write affects only beats accepted after the write cycle. The bench stamps every expected beat with its due cycle and checks that stamp only in stall-free stretches. In stretches with random `out_ready` it checks order, values and output stability instead. Refused writes are shown to have no effect by running a later frame through the data path and checking that the old coefficient is still used.

// File: rtl/qwin_pkg.sv
package qwin_pkg;

  // Hann coefficient for point n of a len-point frame, scaled by one (Q1.x).
  function automatic int hann_q(input int n, input int len, input int one);
    real ph;
    ph = 6.283185307179586 * n / len;
    return $rtoi((1.0 - $cos(ph)) * (one / 2) + 0.5);
  endfunction

  // Bit index width for a count that may be 1.
  function automatic int idx_w(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/qwin_coef_tbl.sv
module qwin_coef_tbl
  import qwin_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 64,
  parameter int CW    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_ok,
  input  logic [$clog2(DEPTH)-1:0]   wr_addr,
  input  logic [CW-1:0]              wr_data,
  input  logic                       rd_en,
  input  logic [$clog2(DEPTH)-1:0]   base_idx,
  output logic [LANES*CW-1:0]        coef_o
);
  localparam int AW  = $clog2(DEPTH);
  localparam int ONE = 1 << (CW - 1);

  logic [CW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CW'(hann_q(i, DEPTH, ONE));
    end else if (wr_ok) begin
      mem[wr_addr] <= wr_data;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_rd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     coef_o[k*CW +: CW] <= '0;
      else if (rd_en) coef_o[k*CW +: CW] <= mem[base_idx + AW'(k)];
    end
  end

endmodule

// File: rtl/qwin_frame_ctrl.sv
module qwin_frame_ctrl
  import qwin_pkg::*;
#(
  parameter int CYC = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_fire,
  input  logic                    in_sof,
  input  logic                    pipe_busy,
  input  logic                    cw_we,
  output logic [idx_w(CYC)-1:0]   pos_o,
  output logic                    wr_ok,
  output logic                    err_o
);
  localparam int CBW = idx_w(CYC);

  logic [CBW-1:0] cnt;
  logic           open_q;
  logic           last_beat;
  logic           busy;

  assign pos_o     = in_sof ? '0 : cnt;
  assign last_beat = (pos_o == CBW'(CYC - 1));
  assign busy      = open_q || pipe_busy;
  assign wr_ok     = cw_we && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      open_q <= 1'b0;
    end else if (in_fire) begin
      cnt    <= last_beat ? '0 : pos_o + CBW'(1);
      open_q <= !last_beat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            err_o <= 1'b0;
    else if (cw_we && busy) err_o <= 1'b1;
  end

  AST_WR_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_we && busy) |=> err_o); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o); // R9
  AST_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |-> !open_q && !pipe_busy); // R8

endmodule

// File: rtl/qwin_lane.sv
module qwin_lane #(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 en_s2,
  input  logic signed [DW-1:0] x_re,
  input  logic signed [DW-1:0] x_im,
  input  logic [CW-1:0]        w,
  output logic signed [DW-1:0] y_re,
  output logic signed [DW-1:0] y_im
);
  localparam int PW = DW + CW + 1;
  localparam int FB = CW - 1;
  localparam logic signed [PW-1:0] HALF = PW'(64'd1 << (FB - 1));
  localparam logic signed [PW-1:0] MAXW = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] MINW = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  function automatic logic signed [PW-1:0] mul_w(input logic signed [DW-1:0] x,
                                                 input logic [CW-1:0] c);
    return $signed(PW'(x)) * $signed(PW'({1'b0, c}));
  endfunction

  function automatic logic signed [PW-1:0] rnd(input logic signed [PW-1:0] p);
    return (p + HALF) >>> FB;
  endfunction

  function automatic logic signed [DW-1:0] clip(input logic signed [PW-1:0] r);
    if (r > MAXW) return MAXW[DW-1:0];
    if (r < MINW) return MINW[DW-1:0];
    return r[DW-1:0];
  endfunction

  logic signed [PW-1:0] p_re, p_im;
  logic signed [DW-1:0] xr2, xi2;
  logic signed [PW-1:0] r_re, r_im;
  logic                 hi_re, lo_re, hi_im, lo_im;

  assign r_re  = rnd(p_re);
  assign r_im  = rnd(p_im);
  assign hi_re = r_re > MAXW;
  assign lo_re = r_re < MINW;
  assign hi_im = r_im > MAXW;
  assign lo_im = r_im < MINW;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_re <= '0; p_im <= '0; xr2 <= '0; xi2 <= '0;
      y_re <= '0; y_im <= '0;
    end else if (adv) begin
      p_re <= mul_w(x_re, w);
      p_im <= mul_w(x_im, w);
      xr2  <= x_re;
      xi2  <= x_im;
      y_re <= en_s2 ? clip(r_re) : xr2;
      y_im <= en_s2 ? clip(r_im) : xi2;
    end
  end

  AST_CLIP_HI_RE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && en_s2 && hi_re) |=> (y_re == MAXW[DW-1:0])); // R4
  AST_CLIP_LO_RE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && en_s2 && lo_re) |=> (y_re == MINW[DW-1:0])); // R4
  AST_CLIP_HI_IM: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && en_s2 && hi_im) |=> (y_im == MAXW[DW-1:0])); // R4
  AST_CLIP_LO_IM: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && en_s2 && lo_im) |=> (y_im == MINW[DW-1:0])); // R4

endmodule

// File: rtl/qwin_window4.sv
module qwin_window4
  import qwin_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int DW        = 16,
  parameter int CW        = 16,
  parameter int FRAME_LEN = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         win_en,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic                         in_sof,
  input  logic [LANES*DW-1:0]          in_re,
  input  logic [LANES*DW-1:0]          in_im,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic                         out_sof,
  output logic [LANES*DW-1:0]          out_re,
  output logic [LANES*DW-1:0]          out_im,
  input  logic                         cw_we,
  input  logic [$clog2(FRAME_LEN)-1:0] cw_addr,
  input  logic [CW-1:0]                cw_data,
  output logic                         cw_err
);
  localparam int CYC = FRAME_LEN / LANES;
  localparam int AW  = $clog2(FRAME_LEN);
  localparam int CBW = idx_w(CYC);

  logic                   adv, in_fire, pipe_busy, wr_ok;
  logic [CBW-1:0]         pos;
  logic [AW-1:0]          base_idx;
  logic [LANES*CW-1:0]    coef1;
  logic [LANES*DW-1:0]    re1, im1;
  logic                   v1, v2, sof1, sof2, en1, en2;
  logic [1:0]             live;

  // Single stall domain: the sink's ready moves every stage at once.
  assign adv       = out_ready;
  assign in_ready  = adv;
  assign in_fire   = in_valid && adv;
  assign pipe_busy = v1 || v2 || out_valid;
  assign base_idx  = AW'(pos) * AW'(LANES);

  qwin_frame_ctrl #(.CYC(CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_fire(in_fire), .in_sof(in_sof),
    .pipe_busy(pipe_busy), .cw_we(cw_we), .pos_o(pos), .wr_ok(wr_ok),
    .err_o(cw_err)
  );

  qwin_coef_tbl #(.LANES(LANES), .DEPTH(FRAME_LEN), .CW(CW)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_addr(cw_addr),
    .wr_data(cw_data), .rd_en(adv), .base_idx(base_idx), .coef_o(coef1)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; out_valid <= 1'b0;
      sof1 <= 1'b0; sof2 <= 1'b0; out_sof <= 1'b0;
      en1 <= 1'b0; en2 <= 1'b0;
      re1 <= '0; im1 <= '0;
    end else if (adv) begin
      v1 <= in_valid;            sof1 <= in_valid && in_sof; en1 <= win_en;
      v2 <= v1;                  sof2 <= sof1;               en2 <= en1;
      out_valid <= v2;           out_sof <= sof2;
      re1 <= in_re;              im1 <= in_im;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    qwin_lane #(.DW(DW), .CW(CW)) u_lane (
      .clk(clk), .rst_n(rst_n), .adv(adv), .en_s2(en2),
      .x_re(re1[k*DW +: DW]), .x_im(im1[k*DW +: DW]), .w(coef1[k*CW +: CW]),
      .y_re(out_re[k*DW +: DW]), .y_im(out_im[k*DW +: DW])
    );
  end

  // Cycles since reset, saturating, so that history checks never reach back past reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         live <= '0;
    else if (live != 2'd3) live <= live + 2'd1;
  end

  AST_THREE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (live == 2'd3 && $past(in_valid && out_ready, 3) && $past(out_ready, 2) && $past(out_ready))
      |-> out_valid); // R6
  AST_SOF_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im) && $stable(out_sof))); // R7
  AST_READY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == out_ready); // R7

endmodule

// File: tb/qwin_window4_tb.sv
module qwin_window4_tb;
  localparam int L = 4, DW = 16, CW = 16, N = 64, C = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, win_en, in_valid, in_ready, in_sof, out_valid, out_ready, out_sof;
  logic [L*DW-1:0] in_re, in_im, out_re, out_im;
  logic cw_we, cw_err;
  logic [5:0] cw_addr;
  logic [CW-1:0] cw_data;

  qwin_window4 u_dut (
    .clk(clk), .rst_n(rst_n), .win_en(win_en), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_re(in_re), .in_im(in_im), .out_valid(out_valid),
    .out_ready(out_ready), .out_sof(out_sof), .out_re(out_re), .out_im(out_im),
    .cw_we(cw_we), .cw_addr(cw_addr), .cw_data(cw_data), .cw_err(cw_err)
  );

  typedef struct {
    logic [L*DW-1:0] re;
    logic [L*DW-1:0] im;
    logic            sof;
    int              due;
    string           tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0, cyc = 0, bpos = 0;
  int tbl[N];
  int rng = 32'h1357;
  bit lat_on = 1'b1, stall_mode = 1'b0, hold_prev = 1'b0, finished = 1'b0;
  logic [L*DW-1:0] held_re, held_im;
  logic held_sof;

  logic d_valid, d_sof, d_en, d_rdy, d_we;
  logic [L*DW-1:0] d_re, d_im;
  logic [5:0] d_addr;
  logic [CW-1:0] d_data;
  string d_tag;

  task automatic check(input string tag, input bit ok, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // Expected windowed part: round half up by floor division, then clip.
  function automatic int wmul(input int x, input int w);
    longint p, r;
    p = longint'(x) * longint'(w) + 64'sd16384;
    if (p >= 0) r = p / 32768;
    else        r = -((-p + 32767) / 32768);
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  function automatic int nxt();
    rng = rng * 1103515245 + 12345;
    return int'($signed(rng[23:8]));
  endfunction

  task automatic step();
    exp_t e;
    int c;
    in_valid = d_valid; in_sof = d_sof; win_en = d_en; in_re = d_re; in_im = d_im;
    out_ready = d_rdy; cw_we = d_we; cw_addr = d_addr; cw_data = d_data;
    if (hold_prev) begin
      check("R7", out_valid === 1'b1 && out_re === held_re && out_im === held_im && out_sof === held_sof,
            "stalled output moved", longint'(out_re[15:0]), longint'(held_re[15:0]));
    end
    hold_prev = out_valid && !d_rdy;
    held_re = out_re; held_im = out_im; held_sof = out_sof;
    if (out_valid === 1'b1 && d_rdy) begin
      if (q.size() == 0) begin
        check("R6", 1'b0, "unexpected output beat", 1, 0);
      end else begin
        e = q.pop_front();
        check(e.tag, out_re === e.re, "re", longint'(out_re), longint'(e.re));
        check(e.tag, out_im === e.im, "im", longint'(out_im), longint'(e.im));
        check("R6", out_sof === e.sof, "sof", longint'(out_sof), longint'(e.sof));
        if (lat_on) check("R6", cyc == e.due, "latency cycle", cyc, e.due);
      end
    end
    if (d_valid && d_rdy) begin
      c = d_sof ? 0 : bpos;
      bpos = (c + 1) % C;
      e.sof = d_sof; e.due = cyc + 3; e.tag = d_tag;
      for (int k = 0; k < L; k++) begin
        int xr, xi;
        xr = int'($signed(d_re[k*DW +: DW]));
        xi = int'($signed(d_im[k*DW +: DW]));
        e.re[k*DW +: DW] = d_en ? 16'(wmul(xr, tbl[4*c+k])) : 16'(xr);
        e.im[k*DW +: DW] = d_en ? 16'(wmul(xi, tbl[4*c+k])) : 16'(xi);
      end
      q.push_back(e);
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  task automatic beat(input bit sof, input bit en, input string tag, input int mode);
    d_valid = 1'b1; d_sof = sof; d_en = en; d_tag = tag;
    for (int k = 0; k < L; k++) begin
      int a, b;
      case (mode)
        1: begin a = (k[0]) ? -32768 : 32767; b = (k[1]) ? 32767 : -32768; end
        2: begin a = 1000 * k - 1500; b = -a; end
        default: begin a = nxt(); b = nxt(); end
      endcase
      d_re[k*DW +: DW] = 16'(a);
      d_im[k*DW +: DW] = 16'(b);
    end
    do begin
      d_rdy = stall_mode ? (($urandom % 3) != 0) : 1'b1;
      step();
    end while (!out_ready);
    d_valid = 1'b0; d_sof = 1'b0;
  endtask

  task automatic frame(input bit en, input string tag, input int mode);
    for (int c = 0; c < C; c++) beat(c == 0, en, tag, mode);
  endtask

  task automatic drain();
    d_valid = 1'b0; d_rdy = 1'b1;
    for (int i = 0; i < 20 && (q.size() != 0 || out_valid === 1'b1); i++) step();
    step();
    check("R6", q.size() == 0, "beats missing after drain", q.size(), 0);
  endtask

  task automatic twrite(input int a, input int v, input bit upd);
    d_we = 1'b1; d_addr = 6'(a); d_data = 16'(v); d_valid = 1'b0; d_rdy = 1'b1;
    step();
    d_we = 1'b0;
    if (upd) tbl[a] = v;
  endtask

  initial begin
    for (int n = 0; n < N; n++)
      tbl[n] = $rtoi((1.0 - $cos(2.0 * 3.141592653589793 * n / N)) * 16384.0 + 0.5);
    rst_n = 1'b0;
    d_valid = 0; d_sof = 0; d_en = 1; d_rdy = 0; d_we = 0; d_addr = 0; d_data = 0;
    d_re = '0; d_im = '0; d_tag = "R1";
    in_valid = 0; in_sof = 0; win_en = 0; in_re = '0; in_im = '0; out_ready = 0;
    cw_we = 0; cw_addr = 0; cw_data = 0;
    repeat (3) @(negedge clk);
    check("R1", out_valid === 1'b0, "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", out_valid === 1'b0 && cw_err === 1'b0, "state after reset",
          {out_valid, cw_err}, 0);
    out_ready = 1'b0; #1;
    check("R7", in_ready === 1'b0, "in_ready low follows sink", in_ready, 0);
    out_ready = 1'b1; #1;
    check("R7", in_ready === 1'b1, "in_ready high follows sink", in_ready, 1);
    @(negedge clk);

    // Reset-loaded Hann table, several data patterns.
    frame(1'b1, "R1 R2 R3", 0);
    frame(1'b1, "R1 R3", 2);
    frame(1'b1, "R1 R3 R4", 1);
    drain();
    // Pass-through, including extreme values.
    frame(1'b0, "R5", 1);
    frame(1'b0, "R5", 0);
    for (int c = 0; c < C; c++) beat(c == 0, c[0], "R3 R5", 0);
    drain();

    // Idle table rewrites: ramp with 0, 1.0 and near-2.0 entries.
    for (int n = 0; n < N; n++) twrite(n, (n * 1031 + 7) & 16'hFFFF, 1'b1);
    twrite(5, 16'hFFFF, 1'b1);
    twrite(6, 0, 1'b1);
    twrite(9, 32768, 1'b1);
    check("R8", cw_err === 1'b0, "idle writes raised error", cw_err, 0);
    frame(1'b1, "R8 R3 R4", 1);
    for (int f = 0; f < 4; f++) frame(1'b1, "R8 R3 R4", 0);
    drain();

    // Random back-pressure.
    stall_mode = 1'b1; lat_on = 1'b0;
    for (int f = 0; f < 6; f++) frame(1'b1, "R7 R3", 0);
    frame(1'b0, "R7 R5", 0);
    stall_mode = 1'b0;
    drain();
    lat_on = 1'b1;

    // Frame restart mid-frame and position wrap without a new start.
    for (int c = 0; c < 5; c++) beat(c == 0, 1'b1, "R2", 0);
    for (int c = 0; c < 2 * C; c++) beat(c == 0, 1'b1, "R2", 0);
    drain();

    // Refused writes: inside an open frame, then while only the pipeline is busy.
    for (int c = 0; c < 3; c++) beat(c == 0, 1'b1, "R9", 0);
    check("R9", cw_err === 1'b0, "error before busy write", cw_err, 0);
    twrite(2, 16'h1234, 1'b0);
    check("R9", cw_err === 1'b1, "error after busy write", cw_err, 1);
    for (int c = 3; c < C; c++) beat(1'b0, 1'b1, "R9", 0);
    twrite(7, 16'h0100, 1'b0);
    drain();
    check("R9", cw_err === 1'b1, "error stays set", cw_err, 1);
    frame(1'b1, "R9 table unchanged", 2);
    frame(1'b1, "R9 table unchanged", 0);
    drain();
    twrite(3, 16'h2000, 1'b1);
    frame(1'b1, "R8 R9", 0);
    drain();
    check("R9", cw_err === 1'b1, "error still set after idle write", cw_err, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule